// File: doc/BRIEF.md
# Cascadable Full Flag and Next-Free Slot Finder

This block watches the per-entry empty bits of a small associative memory and turns them into two things a stacked system needs: an active-low full flag that ripples down a chain of identical stages, and the address of the lowest-numbered empty entry. Each stage takes an active-low full indication from the stage above it and drives its own active-low full indication to the stage below. The topmost stage has its chain input tied low. The bottom stage's chain output is the full flag for the whole system.

The empty vector and a control enable bit are registered inside the block, so they take effect one clock after they are presented. The chain input is combinational and passes straight through to the outputs, so a long chain settles within a single cycle.

When the enable is set, a stage reports "full" downstream only if it has no empty entry and everything above it is also full. When the enable is clear, the stage is transparent and copies its chain input to its chain output. The stage whose chain input reads "full" and whose chain output reads "not full" holds the system's next free slot, and it reports this on a dedicated owner flag.

Top module: `nextFreeChain`

## Requirements
- R1: While reset is held and after its release, the stored empty vector is all ones and the stored enable is 0, so the full output equals the full input until new values are captured.
- R2: The empty vector and the enable bit presented before a rising clock edge govern the outputs from that edge onward, and not before.
- R3: With the stored enable at 1, fullOutN is 0 exactly when fullInN is 0 and no stored empty bit is set. Otherwise fullOutN is 1.
- R4: With the stored enable at 0, fullOutN equals fullInN whatever the empty vector holds.
- R5: nextFreeAddr is the index of the lowest set bit of the stored empty vector. It is 0 when no bit is set.
- R6: nextFreeValid is 1 exactly when fullInN is 0 and at least one stored empty bit is set.
- R7: ownsNextFree is 1 exactly when fullInN is 0 and fullOutN is 1.
- R8: A change on fullInN reaches fullOutN, nextFreeValid and ownsNextFree in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| entryEmptyIn | input | ENTRIES | One bit per entry, 1 means the entry is empty |
| flagEnIn | input | 1 | Control bit: 1 lets local emptiness gate the full flag |
| fullInN | input | 1 | Active-low full indication from the stage above |
| fullOutN | output | 1 | Active-low full indication to the stage below |
| nextFreeAddr | output | ADDR_W | Lowest-indexed empty entry |
| nextFreeValid | output | 1 | The chain above is full and this stage has an empty entry |
| ownsNextFree | output | 1 | This stage holds the system-wide next free slot |

## Verification
The empty vector is driven through several patterns: all empty, none empty, a single bit at the bottom index, a single bit at the top index, alternating bits, and a long pseudo-random run. The all-empty and none-empty cases separate the two sides of the full decision. The single-bit cases pin down both ends of the priority encoder, and the alternating pattern shows that the lowest set bit wins. Each pattern is applied with the chain input both high and low and with the enable both set and clear, which separates bypass behaviour from gated behaviour and shows when the owner flag may rise. A reference model that lags the inputs by one capture edge checks the one-cycle capture against a same-cycle change on the chain input.

// File: rtl/nextFreePkg.sv
package nextFreePkg;
  // Control-to-datapath strobes: the registered view of the stage's inputs.
  typedef struct packed {
    logic flagEn;
  } ctlStrobes_t;
endpackage

// File: rtl/nextFreeCtl.sv
module nextFreeCtl
  import nextFreePkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRIES-1:0] entryEmptyIn,
  input  logic               flagEnIn,
  output logic [ENTRIES-1:0] emptyMask,
  output ctlStrobes_t        strobes
);

  logic [ENTRIES-1:0] emptyQ;
  logic               flagEnQ;

  // Reset marks every entry empty and leaves the full flag in bypass.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      emptyQ  <= '1;
      flagEnQ <= 1'b0;
    end else begin
      emptyQ  <= entryEmptyIn;
      flagEnQ <= flagEnIn;
    end
  end

  assign emptyMask      = emptyQ;
  assign strobes.flagEn = flagEnQ;

  // R1: on the first edge after reset release, the reset state is still held
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (emptyQ == '1 && !flagEnQ));

  // R2: the stored state follows the inputs of the previous cycle
  a_r2_capture: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (emptyQ == $past(entryEmptyIn) && flagEnQ == $past(flagEnIn)));

endmodule

// File: rtl/nextFreeDp.sv
module nextFreeDp
  import nextFreePkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRIES-1:0] emptyMask,
  input  ctlStrobes_t        strobes,
  input  logic               fullInN,
  output logic               fullOutN,
  output logic [ADDR_W-1:0]  nextFreeAddr,
  output logic               nextFreeValid,
  output logic               ownsNextFree
);

  logic anyEmpty;
  logic [ADDR_W-1:0] lowIdx;

  assign anyEmpty = |emptyMask;

  // Priority encoder: scan from the top so the lowest set bit is written last.
  always_comb begin
    lowIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (emptyMask[i]) lowIdx = ADDR_W'(i);
    end
  end

  // Active low: the stage is full only if the chain above is full and it has no empty entry.
  assign fullOutN      = strobes.flagEn ? (fullInN | anyEmpty) : fullInN;
  assign nextFreeAddr  = lowIdx;
  assign nextFreeValid = !fullInN && anyEmpty;
  assign ownsNextFree  = !fullInN && fullOutN;

  // R5: whenever a slot is reported, the reported address really is empty
  a_r5_addr_is_empty: assert property (@(posedge clk) disable iff (!rstN)
    nextFreeValid |-> emptyMask[nextFreeAddr]);

  // R4: in bypass the chain output mirrors the chain input
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flagEn |-> (fullOutN == fullInN));

  // R3: "full" can never appear downstream while the chain above is not full
  a_r3_full_needs_chain: assert property (@(posedge clk) disable iff (!rstN)
    !fullOutN |-> !fullInN);

  // R7: with gating enabled, ownership implies a valid free slot
  a_r7_owner_has_slot: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flagEn && ownsNextFree) |-> nextFreeValid);

endmodule

// File: rtl/nextFreeChain.sv
module nextFreeChain
  import nextFreePkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int ADDR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ENTRIES-1:0] entryEmptyIn,
  input  logic               flagEnIn,
  input  logic               fullInN,
  output logic               fullOutN,
  output logic [ADDR_W-1:0]  nextFreeAddr,
  output logic               nextFreeValid,
  output logic               ownsNextFree
);

  logic [ENTRIES-1:0] emptyMask;
  ctlStrobes_t        strobes;

  nextFreeCtl #(.ENTRIES(ENTRIES)) uCtl (
    .clk          (clk),
    .rstN         (rstN),
    .entryEmptyIn (entryEmptyIn),
    .flagEnIn     (flagEnIn),
    .emptyMask    (emptyMask),
    .strobes      (strobes)
  );

  nextFreeDp #(.ENTRIES(ENTRIES)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .emptyMask     (emptyMask),
    .strobes       (strobes),
    .fullInN       (fullInN),
    .fullOutN      (fullOutN),
    .nextFreeAddr  (nextFreeAddr),
    .nextFreeValid (nextFreeValid),
    .ownsNextFree  (ownsNextFree)
  );

endmodule

// File: tb/tb_nextFreeChain.sv
`timescale 1ns/1ps
module tb_nextFreeChain;
  localparam int ENTRIES = 16;
  localparam int ADDR_W  = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rstN;
  logic [ENTRIES-1:0] entryEmptyIn;
  logic flagEnIn;
  logic fullInN;
  logic fullOutN;
  logic [ADDR_W-1:0] nextFreeAddr;
  logic nextFreeValid;
  logic ownsNextFree;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;

  // Reference state: values seen at the last capture edge.
  logic [ENTRIES-1:0] mEmpty;
  logic mEn;

  always #10 clk = ~clk;  // 50 MHz

  nextFreeChain #(.ENTRIES(ENTRIES)) dut (
    .clk(clk), .rstN(rstN), .entryEmptyIn(entryEmptyIn), .flagEnIn(flagEnIn),
    .fullInN(fullInN), .fullOutN(fullOutN), .nextFreeAddr(nextFreeAddr),
    .nextFreeValid(nextFreeValid), .ownsNextFree(ownsNextFree)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) begin
      mEmpty <= '1;
      mEn    <= 1'b0;
    end else begin
      mEmpty <= entryEmptyIn;
      mEn    <= flagEnIn;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Compare every output with the model.
  task automatic checkAll();
    int lowest;
    logic any;
    logic expFull;
    any = (mEmpty != 0);
    lowest = 0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (mEmpty[i]) lowest = i;
    if (mEn) expFull = !(!fullInN && !any);
    else     expFull = fullInN;
    chk(mEn ? "R3 fullOutN" : "R4 fullOutN", int'(fullOutN), int'(expFull));
    chk("R5 nextFreeAddr", int'(nextFreeAddr), lowest);
    chk("R6 nextFreeValid", int'(nextFreeValid), int'(!fullInN && any));
    chk("R7 ownsNextFree", int'(ownsNextFree), int'(!fullInN && expFull));
  endtask

  // Present inputs at the falling edge, then check at the next falling edge.
  task automatic step(input logic [ENTRIES-1:0] e, input logic en, input logic fi);
    entryEmptyIn = e;
    flagEnIn = en;
    fullInN = fi;
    @(negedge clk);
    checkAll();
  endtask

  initial begin : watchdog
    #(20 * 100000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    entryEmptyIn = '0;
    flagEnIn = 1'b1;
    fullInN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: during reset the full output follows the chain input
    chk("R1 reset bypass", int'(fullOutN), 0);
    chk("R1 reset addr", int'(nextFreeAddr), 0);
    fullInN = 1'b1;
    #1 chk("R1 reset bypass hi", int'(fullOutN), 1);
    rstN = 1'b1;
    fullInN = 1'b0;
    #1 chk("R1 after release valid", int'(nextFreeValid), 1);
    // R2: an enable with an empty-free vector does not act before the edge
    entryEmptyIn = '0;
    flagEnIn = 1'b1;
    #1 chk("R2 before edge", int'(fullOutN), 0);
    @(negedge clk);
    chk("R2 after edge", int'(fullOutN), 0);
    checkAll();
    entryEmptyIn = 16'h0001;
    #1 chk("R2 hold before edge", int'(fullOutN), 0);
    @(negedge clk);
    chk("R2 new empty captured", int'(fullOutN), 1);

    // Directed patterns under every combination of enable and chain input.
    for (int en = 0; en < 2; en++) begin
      for (int fi = 0; fi < 2; fi++) begin
        step('1,           en[0], fi[0]);
        step('0,           en[0], fi[0]);
        step(16'h0001,     en[0], fi[0]);
        step(16'h8000,     en[0], fi[0]);
        step(16'hAAAA,     en[0], fi[0]);
        step(16'h0550,     en[0], fi[0]);
      end
    end

    // R8: the chain input changes between edges and the outputs follow at once
    step('0, 1'b1, 1'b0);
    fullInN = 1'b1;
    #2 chk("R8 comb fullOutN", int'(fullOutN), 1);
    chk("R8 comb owner", int'(ownsNextFree), 0);
    fullInN = 1'b0;
    #2 chk("R8 comb fullOutN low", int'(fullOutN), 0);
    step(16'h0100, 1'b1, 1'b0);
    chk("R7 owner with slot", int'(ownsNextFree), 1);
    chk("R5 mid index", int'(nextFreeAddr), 8);

    // R4: in bypass the empty vector does not touch the chain output
    step('0, 1'b0, 1'b1);
    chk("R4 bypass high", int'(fullOutN), 1);

    for (int k = 0; k < 400; k++) begin
      logic [ENTRIES-1:0] e;
      e = ENTRIES'($urandom);
      if (($urandom % 4) == 0) e = '0;
      if (($urandom % 5) == 0) e = ENTRIES'(1) << ($urandom % ENTRIES);
      step(e, 1'($urandom), 1'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule